// File: doc/BRIEF.md
# Channel-Aligned Carrier Mixer

This block multiplies a time-multiplexed multichannel sample stream by carrier values that come from a separate oscillator stream. Each of the two input streams has its own valid strobe, channel number and sample. The two streams may reach the block with different latencies, and those latencies are not known in advance. The block does not try to match a fixed delay. Each arriving carrier sample is written into a small memory at the slot for its channel. The sample stream then reads that memory back with its own channel number.

The product leaves the block with the valid strobe and channel number of the sample stream, after a fixed pipeline of two clock cycles. One cycle is for the memory read and one is for the registered multiplier. The product keeps full precision: two Q4.11 operands give a Q9.22 result. The block does not round or saturate. The number of channels in use and the upstream latencies can change without any change to the design, as long as channel numbers stay below the memory depth.

No state machine is needed. The block is a straight pipeline: a store stage, a multiply stage and a matching sideband delay line.

Top module: `chan_carrier_mixer`

## Requirements
- R1: After reset, `out_vld` is low, and every carrier slot holds zero, so a channel that has never been written produces a product of 0.
- R2: When `car_vld` is 1, `car_samp` is stored in the slot addressed by `car_chan`.
- R3: When `car_vld` is 0, the carrier slots keep their contents, whatever values `car_chan` and `car_samp` carry.
- R4: `out_prod` equals the signed product of the sample and the carrier value held in the slot addressed by `dat_chan`. It is 32 bits wide, two's complement, with 22 fractional bits.
- R5: `out_vld` and `out_chan` repeat `dat_vld` and `dat_chan` exactly two cycles later, and `out_prod` belongs to that same sample.
- R6: If a carrier write and a sample read address the same slot in the same cycle, the product uses the value that was stored before that write.
- R7: Only the low 4 bits of a channel number select a slot. For example, channels 17 and 1 share slot 1.
- R8: Negative operands and full-scale extremes give exact products. For example, -32768 × -32768 gives 2^30.
- R9: The output stream follows only the sample stream's timing. Carrier traffic at any offset or rate has no effect on `out_vld` or `out_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dat_vld | input | 1 | Sample stream valid |
| dat_chan | input | 8 | Sample stream channel number |
| dat_samp | input | 16 | Sample, signed Q4.11 |
| car_vld | input | 1 | Carrier stream valid |
| car_chan | input | 8 | Carrier stream channel number |
| car_samp | input | 16 | Carrier value, signed Q4.11 |
| out_vld | output | 1 | Product valid |
| out_chan | output | 8 | Product channel number |
| out_prod | output | 32 | Product, signed Q9.22 |

## Verification
The assertions check the following on every cycle:
- the two-cycle timing of the output valid strobe and channel number against the sample stream;
- a zero read from any slot that has not yet been written;
- a zero product whenever either operand is zero.

Other behaviours depend on the history of writes. These are the product values, read-before-write on a same-slot collision, aliasing of channel numbers above 15, and immunity to carrier timing. Only the bench scenarios can show these. The bench keeps its own model of the slots and compares every output sample against it.

// File: rtl/cmix_pkg.sv
package cmix_pkg;
    localparam int unsigned SAMP_W  = 16;
    localparam int unsigned CHAN_W  = 8;
    localparam int unsigned DEPTH   = 16;
    localparam int unsigned ADDR_W  = $clog2(DEPTH);
    localparam int unsigned PROD_W  = 2 * SAMP_W;
    localparam int unsigned RD_LAT  = 1;
    localparam int unsigned MUL_LAT = 1;
    localparam int unsigned PIPE_LAT = RD_LAT + MUL_LAT;

    typedef struct packed {
        logic              vld;
        logic [CHAN_W-1:0] chan;
    } side_t;
endpackage

// File: rtl/cmix_delay.sv
module cmix_delay #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [DEPTH+1];

    assign stage[0] = din;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage[i+1] <= '0;
            end else begin
                stage[i+1] <= stage[i];
            end
        end
    end

    assign dout = stage[DEPTH];
endmodule

// File: rtl/cmix_carrier_store.sv
module cmix_carrier_store #(
    parameter int unsigned W      = 16,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_q
);
    logic [W-1:0] slot [DEPTH];

    // Writes and the registered read share one clock edge, so a same-slot
    // read returns the value held before the write (read-before-write).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot[i] <= '0;
            end
            rd_q <= '0;
        end else begin
            if (wr_en) begin
                slot[wr_addr] <= wr_data;
            end
            rd_q <= slot[rd_addr];
        end
    end

    // Checker state: which slots have been written since reset.
    logic [DEPTH-1:0] seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (wr_en) begin
            seen[wr_addr] <= 1'b1;
        end
    end

    p_unwritten_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen[rd_addr] |=> (rd_q == '0));
endmodule

// File: rtl/cmix_mult.sv
module cmix_mult #(
    parameter int unsigned W = 16,
    localparam int unsigned PW = 2 * W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [W-1:0]  op_a,
    input  logic signed [W-1:0]  op_b,
    output logic signed [PW-1:0] prod
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod <= '0;
        end else begin
            prod <= op_a * op_b;
        end
    end

    p_zero_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_a == '0) || (op_b == '0)) |=> (prod == '0));
endmodule

// File: rtl/chan_carrier_mixer.sv
module chan_carrier_mixer
    import cmix_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_vld,
    input  logic [CHAN_W-1:0] dat_chan,
    input  logic [SAMP_W-1:0] dat_samp,
    input  logic              car_vld,
    input  logic [CHAN_W-1:0] car_chan,
    input  logic [SAMP_W-1:0] car_samp,
    output logic              out_vld,
    output logic [CHAN_W-1:0] out_chan,
    output logic [PROD_W-1:0] out_prod
);
    logic              car_hi_unused;
    logic [SAMP_W-1:0] car_rd;
    logic [SAMP_W-1:0] samp_d;
    side_t             side_in;
    side_t             side_out;

    assign car_hi_unused = ^car_chan[CHAN_W-1:ADDR_W];

    cmix_carrier_store #(.W(SAMP_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (car_vld),
        .wr_addr (car_chan[ADDR_W-1:0]),
        .wr_data (car_samp),
        .rd_addr (dat_chan[ADDR_W-1:0]),
        .rd_q    (car_rd)
    );

    cmix_delay #(.W(SAMP_W), .DEPTH(RD_LAT)) u_samp_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (dat_samp),
        .dout  (samp_d)
    );

    cmix_mult #(.W(SAMP_W)) u_mult (
        .clk   (clk),
        .rst_n (rst_n),
        .op_a  (samp_d),
        .op_b  (car_rd),
        .prod  (out_prod)
    );

    assign side_in = '{vld: dat_vld, chan: dat_chan};

    cmix_delay #(.W($bits(side_t)), .DEPTH(PIPE_LAT)) u_side_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (side_in),
        .dout  (side_out)
    );

    assign out_vld  = side_out.vld;
    assign out_chan = side_out.chan;

    // Checker state: edges seen since reset, saturating at two.
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    p_vld_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (out_vld == $past(dat_vld, 2)));
    p_chan_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (out_chan == $past(dat_chan, 2)));
endmodule

// File: tb/chan_carrier_mixer_bench.sv
module chan_carrier_mixer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dat_vld = 1'b0;
    logic [7:0]  dat_chan = '0;
    logic [15:0] dat_samp = '0;
    logic        car_vld = 1'b0;
    logic [7:0]  car_chan = '0;
    logic [15:0] car_samp = '0;
    logic        out_vld;
    logic [7:0]  out_chan;
    logic [31:0] out_prod;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit mon_on = 0;

    typedef struct {
        logic [7:0]  chan;
        logic [31:0] prod;
        string       req;
    } exp_t;
    exp_t sb[$];

    logic signed [15:0] model [16];

    always #5 clk = ~clk;

    chan_carrier_mixer u_chan_carrier_mixer (
        .clk(clk), .rst_n(rst_n),
        .dat_vld(dat_vld), .dat_chan(dat_chan), .dat_samp(dat_samp),
        .car_vld(car_vld), .car_chan(car_chan), .car_samp(car_samp),
        .out_vld(out_vld), .out_chan(out_chan), .out_prod(out_prod)
    );

    // Drive one cycle at the falling edge; expected values use the slot
    // contents before this cycle's write (read-before-write).
    task automatic step(input logic dv, input logic [7:0] dc, input logic [15:0] ds,
                        input logic cv, input logic [7:0] cc, input logic [15:0] cs,
                        input string req);
        exp_t e;
        dat_vld = dv; dat_chan = dc; dat_samp = ds;
        car_vld = cv; car_chan = cc; car_samp = cs;
        if (dv) begin
            e.chan = dc;
            e.prod = 32'($signed(ds) * model[dc[3:0]]);
            e.req  = req;
            sb.push_back(e);
        end
        if (cv) model[cc[3:0]] = $signed(cs);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 16'h0000, 0, 8'h00, 16'h0000, "idle");
    endtask

    always @(negedge clk) begin
        if (mon_on && out_vld) begin
            exp_t e;
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R5: unexpected output chan=%0d prod=%h, expected none", out_chan, out_prod);
            end else begin
                e = sb.pop_front();
                if (out_chan !== e.chan || out_prod !== e.prod) begin
                    bad++;
                    $display("FAIL %s: chan=%0d prod=%h, expected chan=%0d prod=%h",
                             e.req, out_chan, out_prod, e.chan, e.prod);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        total++;
        if (out_vld !== 1'b0) begin
            bad++;
            $display("FAIL R1: out_vld=%b, expected 0 after reset", out_vld);
        end
        mon_on = 1;

        // R1: unwritten slots give zero products
        step(1, 8'd0, 16'h0800, 0, 8'd0, 16'h0000, "R1");
        step(1, 8'd9, 16'h7fff, 0, 8'd0, 16'h0000, "R1");
        idle(3);

        // R2/R4: write two channel carriers, then alternate samples
        step(0, 8'd0, 16'h0000, 1, 8'd0, 16'h0800, "R2");
        step(0, 8'd0, 16'h0000, 1, 8'd1, 16'hf800, "R2");
        step(1, 8'd0, 16'h0c00, 0, 8'd0, 16'h0000, "R4");
        step(1, 8'd1, 16'h0c00, 0, 8'd0, 16'h0000, "R4");
        step(1, 8'd0, 16'hfa00, 0, 8'd0, 16'h0000, "R4");
        step(1, 8'd1, 16'h1234, 0, 8'd0, 16'h0000, "R4");
        idle(3);

        // R3: carrier values without valid must not land in any slot
        step(0, 8'd0, 16'h0000, 0, 8'd0, 16'h1111, "R3");
        step(0, 8'd0, 16'h0000, 0, 8'd2, 16'h2222, "R3");
        step(1, 8'd0, 16'h0400, 0, 8'd0, 16'h3333, "R3");
        step(1, 8'd2, 16'h0400, 0, 8'd2, 16'h4444, "R3");
        idle(3);

        // R6: same-slot write and read in one cycle
        step(1, 8'd0, 16'h0800, 1, 8'd0, 16'h0300, "R6");
        step(1, 8'd0, 16'h0800, 0, 8'd0, 16'h0000, "R6");
        idle(3);

        // R7: channel 17 aliases slot 1; channel 33 writes slot 1
        step(1, 8'd17, 16'h0800, 0, 8'd0, 16'h0000, "R7");
        step(0, 8'd0, 16'h0000, 1, 8'd33, 16'h0123, "R7");
        step(1, 8'd1, 16'h0800, 0, 8'd0, 16'h0000, "R7");
        step(1, 8'd241, 16'h0800, 0, 8'd0, 16'h0000, "R7");
        idle(3);

        // R8: extremes and signs
        step(0, 8'd0, 16'h0000, 1, 8'd5, 16'h8000, "R8");
        step(0, 8'd0, 16'h0000, 1, 8'd6, 16'h7fff, "R8");
        step(1, 8'd5, 16'h8000, 0, 8'd0, 16'h0000, "R8");
        step(1, 8'd5, 16'h7fff, 0, 8'd0, 16'h0000, "R8");
        step(1, 8'd6, 16'h7fff, 0, 8'd0, 16'h0000, "R8");
        step(1, 8'd6, 16'hffff, 0, 8'd0, 16'h0000, "R8");
        idle(3);

        // R9: continuous carrier updates at another rate and offset,
        // samples arriving in a gapped two-channel pattern
        for (int k = 0; k < 40; k++) begin
            step((k % 3) != 1, 8'((k / 3) % 2), 16'(k * 97 - 1500),
                 1'b1, 8'((k + 1) % 2), 16'(k * 311 - 6000), "R9");
        end
        for (int k = 0; k < 10; k++) begin
            step(1'b0, 8'd0, 16'h0000, 1'b1, 8'(k), 16'(k * 1000), "R9");
        end
        idle(4);

        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R5: %0d outputs missing, expected 0", sb.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule